// File: doc/BRIEF.md
# Double-Buffer Audio DMA Transfer Counter

This block follows the progress of one audio DMA channel, either transmit or receive, as it moves data through a buffer in memory. The channel moves one 32-bit longword per transfer. Software programs the buffer length in bytes, the buffer start address and a few control bits. The DMA engine pulses a strobe each time a longword completes. The block supplies the address of the next longword and raises two interrupts. The mid-buffer interrupt tells the processor that the first half of the buffer is free to refill or drain while the second half is in flight. The end-of-buffer interrupt marks the completion of the whole buffer.

With the reload bit set, the block returns to the start address and the full longword count after the last longword, so ping-pong buffering continues without any reprogramming. Without it, the channel stops after the last longword. A second channel with its own registers and interrupt pair is a second instance of this block.

Top module: `dbuf_dma_ctr`

## Requirements
- R1: After reset `run_o`, `addr_o`, `sts_o`, `irq_half_o` and `irq_all_o` are all zero.
- R2: Register selects: 0 = byte length (longword count L = `wr_data_i[CNT_W+1:2]`, bits 1:0 ignored), 1 = start address (bits 1:0 forced to zero), 2 = control (bit0 run, bit1 reload, bit2 mid-buffer interrupt enable, bit3 end-of-buffer interrupt enable), 3 = status clear.
- R3: Writing control with bit0 set while stopped starts a pass: `addr_o` equals the start address and the completed count is zero. While running, `addr_o` advances by 4 on every `xfer_done_i`. While stopped, strobes change nothing.
- R4: For L of 2 or more, status bit0 (mid-buffer) sets on the strobe that completes longword ceil(L/2): L/2 for even L, and n+1 for a length of 8n+4 bytes.
- R5: For a length of 4 bytes (L = 1), status bit0 never sets and only the end-of-buffer event occurs.
- R6: Status bit1 (end-of-buffer) sets on the strobe that completes longword L.
- R7: With reload set, after longword L `run_o` stays 1, `addr_o` returns to the start address and the count restarts. Length and start address written during a pass take effect from the next pass.
- R8: Without reload, after longword L `run_o` falls to 0, `addr_o` returns to the start address, and later strobes are ignored.
- R9: Status bits stay set until a select-3 write with a one in the matching bit (bit0 mid, bit1 end). If a set and a clear reach the same bit in one cycle, the set wins.
- R10: `irq_half_o` equals status bit0 AND enable bit2. `irq_all_o` equals status bit1 AND enable bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | ADDR_W | Register write data |
| xfer_done_i | input | 1 | One longword completed |
| addr_o | output | ADDR_W | Address of next longword |
| run_o | output | 1 | Channel running |
| sts_o | output | 2 | Sticky status: bit0 mid, bit1 end |
| irq_half_o | output | 1 | Mid-buffer interrupt |
| irq_all_o | output | 1 | End-of-buffer interrupt |

## Verification
The bench walks the buffer lengths where the midpoint rule is easiest to get wrong: 4 bytes, where a design that forgets the exception raises a mid interrupt together with the end one, and odd longword counts such as 12, 20 and 44 bytes, where rounding down instead of up fires the mid interrupt one longword early. It changes the length and start address in the middle of a pass. A design that applies them at once either ends the pass at the wrong count or jumps to the wrong address. It also drives a status clear in the same cycle as a completing strobe, where a design that lets the clear win loses an interrupt. Finally it checks that an ended non-reload pass ignores further strobes and that the enable bits gate the outputs without touching the status bits.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;
  typedef enum logic [1:0] {
    SEL_LEN  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CLR  = 2'd3
  } wr_sel_e;

  localparam int unsigned CTL_RUN = 0;
  localparam int unsigned CTL_RLD = 1;
  localparam int unsigned CTL_HIE = 2;
  localparam int unsigned CTL_AIE = 3;
endpackage

// File: rtl/dbuf_lw_counter.sv
module dbuf_lw_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             half_o,
  output logic             last_o
);
  logic [CNT_W-1:0] total_q, cnt_q, cnt_nxt;
  logic [CNT_W:0]   half_at;

  assign cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  // midpoint rounds up: ceil(L/2)
  assign half_at = ({1'b0, total_q} + {{CNT_W{1'b0}}, 1'b1}) >> 1;
  assign last_o  = step_i && (cnt_nxt == total_q);
  assign half_o  = step_i && (total_q != {{(CNT_W-1){1'b0}}, 1'b1}) &&
                   ({1'b0, cnt_nxt} == half_at);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q <= '0;
      cnt_q   <= '0;
    end else if (load_i || last_o) begin
      total_q <= len_i;  // length shadow refreshed only at pass start
      cnt_q   <= '0;
    end else if (step_i) begin
      cnt_q   <= cnt_nxt;
    end
  end

  // R5: mid and end events never coincide
  p_half_all_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(half_o && last_o));

  // R6: count stays inside the pass
  p_cnt_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (total_q != '0) |-> (cnt_q < total_q));
endmodule

// File: rtl/dbuf_addr_gen.sv
module dbuf_addr_gen #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              wrap_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LW_BYTES = ADDR_W'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_o <= '0;
    else if (load_i || wrap_i)  addr_o <= base_i;
    else if (step_i)            addr_o <= addr_o + LW_BYTES;
  end

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !wrap_i && !load_i |=> addr_o == $past(addr_o) + LW_BYTES);

  p_addr_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> addr_o == $past(base_i));
endmodule

// File: rtl/dbuf_irq.sv
module dbuf_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] set_i,
  input  logic [1:0] clr_i,
  input  logic [1:0] ie_i,
  output logic [1:0] sts_o,
  output logic [1:0] irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_i) | set_i;  // set beats clear
  end

  assign irq_o = sts_o & ie_i;

  p_sticky_half_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[0] && !clr_i[0] |=> sts_o[0]);

  p_sticky_all_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[1] && !clr_i[1] |=> sts_o[1]);

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[1] |=> sts_o[1]);
endmodule

// File: rtl/dbuf_dma_ctr.sv
module dbuf_dma_ctr
  import dbuf_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              xfer_done_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              run_o,
  output logic [1:0]        sts_o,
  output logic              irq_half_o,
  output logic              irq_all_o
);
  logic [CNT_W-1:0]  len_q;
  logic [ADDR_W-1:0] base_q;
  logic              run_q, rld_q, hie_q, aie_q;
  logic              ctl_wr, clr_wr, load, step, half_evt, last_evt;
  logic [1:0]        irq;

  assign ctl_wr = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_CTRL);
  assign clr_wr = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_CLR);
  assign load   = ctl_wr && wr_data_i[CTL_RUN] && !run_q;
  assign step   = xfer_done_i && run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      base_q <= '0;
      run_q  <= 1'b0;
      rld_q  <= 1'b0;
      hie_q  <= 1'b0;
      aie_q  <= 1'b0;
    end else begin
      if (wr_en_i && wr_sel_e'(wr_sel_i) == SEL_LEN)
        len_q <= wr_data_i[CNT_W+1:2];
      if (wr_en_i && wr_sel_e'(wr_sel_i) == SEL_BASE)
        base_q <= {wr_data_i[ADDR_W-1:2], 2'b00};
      if (ctl_wr) begin
        run_q <= wr_data_i[CTL_RUN];
        rld_q <= wr_data_i[CTL_RLD];
        hie_q <= wr_data_i[CTL_HIE];
        aie_q <= wr_data_i[CTL_AIE];
      end else if (last_evt && !rld_q) begin
        run_q <= 1'b0;
      end
    end
  end

  dbuf_lw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .len_i  (len_q),
    .half_o (half_evt),
    .last_o (last_evt)
  );

  dbuf_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .wrap_i (last_evt),
    .base_i (base_q),
    .addr_o (addr_o)
  );

  dbuf_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({last_evt, half_evt}),
    .clr_i  (clr_wr ? wr_data_i[1:0] : 2'b00),
    .ie_i   ({aie_q, hie_q}),
    .sts_o  (sts_o),
    .irq_o  (irq)
  );

  assign run_o      = run_q;
  assign irq_half_o = irq[0];
  assign irq_all_o  = irq[1];

  p_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_evt && !rld_q && !ctl_wr |=> !run_o);

  p_reload_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_evt && rld_q && !ctl_wr |=> run_o);

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !wr_en_i |=> $stable(addr_o));
endmodule

// File: tb/tb_dbuf_dma_ctr.sv
`timescale 1ns/1ps
module tb_dbuf_dma_ctr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        xfer = 1'b0;
  logic [31:0] addr;
  logic        run;
  logic [1:0]  sts;
  logic        irq_h, irq_a;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dbuf_dma_ctr dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .xfer_done_i(xfer), .addr_o(addr), .run_o(run),
    .sts_o(sts), .irq_half_o(irq_h), .irq_all_o(irq_a)
  );

  // lengths in bytes and expected midpoint longword (0 = none)
  localparam int NV = 8;
  localparam int VLEN [NV] = '{4, 8, 12, 16, 20, 28, 32, 44};
  localparam int VHALF[NV] = '{0, 1, 2, 2, 3, 4, 4, 6};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    xfer = 1'b1;
    @(negedge clk);
    xfer = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 addr", addr, 0);
    check("R1 run", {31'b0, run}, 0);
    check("R1 sts", {30'b0, sts}, 0);
    check("R1 irqs", {30'b0, irq_a, irq_h}, 0);

    pulse();
    check("R3 idle strobe addr", addr, 0);
    check("R3 idle strobe sts", {30'b0, sts}, 0);

    for (int i = 0; i < NV; i++) begin
      int l;
      logic [31:0] b;
      l = VLEN[i] / 4;
      b = 32'h100 * (i + 1);
      wr(2'd0, VLEN[i]);
      wr(2'd1, b | 32'h3);
      wr(2'd2, 32'hD);
      check("R2/R3 start addr", addr, b);
      for (int k = 1; k <= l; k++) begin
        pulse();
        check((l == 1) ? "R5 no mid" : "R4 mid", {31'b0, irq_h},
              (VHALF[i] != 0 && k >= VHALF[i]) ? 1 : 0);
        check("R6 end", {31'b0, irq_a}, (k == l) ? 1 : 0);
        check("R3 addr", addr, (k < l) ? b + 4 * k : b);
      end
      check("R8 stopped", {31'b0, run}, 0);
      pulse();
      check("R8 strobe ignored", addr, b);
      check("R8 sts held", {30'b0, sts}, (VHALF[i] != 0) ? 3 : 2);
      wr(2'd3, 32'h3);
      check("R9 w1c", {30'b0, sts}, 0);
    end

    // reload passes
    wr(2'd0, 8);
    wr(2'd1, 32'h2000);
    wr(2'd2, 32'hF);
    pulse(); pulse();
    check("R7 run kept", {31'b0, run}, 1);
    check("R7 wrap addr", addr, 32'h2000);
    check("R6 reload end", {30'b0, sts}, 3);
    wr(2'd3, 32'h3);
    pulse();
    check("R4 pass2 mid", {30'b0, sts}, 1);
    wr(2'd0, 12);
    wr(2'd1, 32'h3000);
    check("R7 addr not moved", addr, 32'h2004);
    pulse();
    check("R7 old len ends", {30'b0, sts}, 3);
    check("R7 new base", addr, 32'h3000);
    wr(2'd3, 32'h3);
    pulse();
    check("R4 new len no mid yet", {30'b0, sts}, 0);
    pulse();
    check("R4 new len mid", {30'b0, sts}, 1);
    pulse();
    check("R7 new len end", {30'b0, sts}, 3);
    check("R7 new len wrap", addr, 32'h3000);

    // gating
    wr(2'd2, 32'h3);
    check("R10 gated", {30'b0, irq_a, irq_h}, 0);
    check("R10 sts kept", {30'b0, sts}, 3);
    wr(2'd2, 32'h7);
    check("R10 mid only", {30'b0, irq_a, irq_h}, 1);
    repeat (5) @(negedge clk);
    check("R9 sticky", {30'b0, sts}, 3);
    wr(2'd3, 32'h1);
    check("R9 partial clear", {30'b0, sts}, 2);

    // set and clear of end bit in one cycle
    pulse(); pulse();
    @(negedge clk);
    xfer = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'h2;
    @(negedge clk);
    xfer = 1'b0; wr_en = 1'b0;
    check("R9 set wins", {30'b0, sts}, 3);

    // software stop
    pulse();
    wr(2'd2, 32'h0);
    check("R3 stopped", {31'b0, run}, 0);
    pulse();
    check("R3 stop holds addr", addr, 32'h3004);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule